// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Excess-One Correction

This block is a purely combinational N-bit adder. It takes two operands and a carry-in and returns an N-bit sum with a carry-out. The operand width is cut into segments that widen toward the most significant end. The lowest segment is a plain ripple chain fed by the external carry-in. Every higher segment computes its sum once, assuming no carry arrives from below. An increment stage then forms that result plus one. A per-bit 2:1 select, steered by the carry that leaves the segment below, picks one of the two words. This replaces the second ripple chain that a classic carry-select segment needs, and the increment stage is far smaller than that chain.

The adder has no clock, no registers and no flow control. Operands go in and a result comes out after the combinational delay. It drops into any datapath that needs a wide add with shorter carry paths than a single ripple chain gives.

Top module: `csla_adder`

## Requirements
- R1: `{cout, sum}` equals the (N+1)-bit value a + b + cin for every input combination.
- R2: Segment widths from the least significant end follow the nominal series 2, 2, 3, 4, 5, 6, ... A segment is the last one when the bits left after it would be fewer than the next nominal width; that last segment takes every remaining bit. For N = 16 this gives bits [1:0], [3:2], [6:4], [10:7], [15:11]. For N = 8 it gives [1:0], [3:2], [7:4].
- R3: The carry entering each segment equals the carry out of the sum of all lower bits plus cin. The carry entering segment 0 is cin, and the carry leaving the top segment is cout.
- R4: With a all ones, b zero and cin = 1, the carry crosses every segment: sum is zero and cout is 1.
- R5: Zero operands give sum = cin and cout = 0.
- R6: With b = ~a, cin = 0 gives sum all ones and cout 0, and cin = 1 gives sum zero and cout 1.
- R7: A segment whose carry-free result is all ones, with no carry of its own, wraps to zero when a carry arrives and passes that carry upward.
- R8: The same RTL is exact at N = 8, 16, 32 and 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of a + b + cin |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
The bench builds four copies at N = 8, 16, 32 and 64 and drives them all from one stimulus. The 8-bit copy has three segments, so it can be swept over every operand and carry pair. The 16-bit copy has the full five-segment series. At 32 and 64 bits the last segment takes a remainder much wider than its nominal width, which exercises the longest increment chains and selects. A carry placed exactly at each bit position reaches every segment boundary at every width.

// File: rtl/csla_pkg.sv
package csla_pkg;

  // Nominal width of segment k: 2, 2, 3, 4, 5, ...
  function automatic int seg_nominal(int k);
    return (k < 2) ? 2 : k + 1;
  endfunction

  // Number of segments for an n-bit adder
  function automatic int seg_count(int n);
    int pos;
    pos = 0;
    for (int k = 0; k < n; k++) begin
      if (pos + seg_nominal(k) + seg_nominal(k + 1) > n) return k + 1;
      pos += seg_nominal(k);
    end
    return n;
  endfunction

  // Lowest bit index of segment g
  function automatic int seg_lo(int n, int g);
    int pos;
    pos = 0;
    for (int k = 0; k < g; k++) pos += seg_nominal(k);
    return (n > 0) ? pos : 0;
  endfunction

  // Width of segment g; the last segment takes every remaining bit
  function automatic int seg_width(int n, int g);
    if (g == seg_count(n) - 1) return n - seg_lo(n, g);
    return seg_nominal(g);
  endfunction

endpackage

// File: rtl/csla_ripple.sv
module csla_ripple #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;

  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]   = a[i] ^ b[i] ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign co = c[W];
endmodule

// File: rtl/csla_excess1.sv
module csla_excess1 #(
  parameter int W = 3
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  // run[i] is high when every bit below i is one
  logic [W-1:0] run;

  assign run[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = x[i] ^ run[i];
    if (i < W - 1) begin : g_run
      assign run[i+1] = run[i] & x[i];
    end
  end
endmodule

// File: rtl/csla_select_seg.sv
module csla_select_seg #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W-1:0] s_zero;
  logic         c_zero;
  logic [W:0]   plus_one;

  // Carry-free chain; the constant zero reduces bit 0 to a half adder
  csla_ripple #(.W(W)) i_chain (
    .a  (a),
    .b  (b),
    .ci (1'b0),
    .s  (s_zero),
    .co (c_zero)
  );

  csla_excess1 #(.W(W + 1)) i_inc (
    .x ({c_zero, s_zero}),
    .y (plus_one)
  );

  assign {co, s} = ci ? plus_one : {c_zero, s_zero};
endmodule

// File: rtl/csla_adder.sv
module csla_adder #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  import csla_pkg::*;

  localparam int NSEG = seg_count(N);

  // seg_carry[g] enters segment g; seg_carry[NSEG] leaves the top
  logic [NSEG:0] seg_carry;

  assign seg_carry[0] = cin;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam int LO = seg_lo(N, g);
    localparam int SW = seg_width(N, g);
    if (g == 0) begin : g_base
      csla_ripple #(.W(SW)) i_base (
        .a  (a[LO +: SW]),
        .b  (b[LO +: SW]),
        .ci (seg_carry[g]),
        .s  (sum[LO +: SW]),
        .co (seg_carry[g+1])
      );
    end else begin : g_sel
      csla_select_seg #(.W(SW)) i_sel (
        .a  (a[LO +: SW]),
        .b  (b[LO +: SW]),
        .ci (seg_carry[g]),
        .s  (sum[LO +: SW]),
        .co (seg_carry[g+1])
      );
    end
  end

  assign cout = seg_carry[NSEG];
endmodule

// File: rtl/csla_adder_chk.sv
module csla_adder_chk #(
  parameter int N = 16
) (
  input logic [N-1:0]                      a,
  input logic [N-1:0]                      b,
  input logic                              cin,
  input logic [N-1:0]                      sum,
  input logic                              cout,
  input logic [csla_pkg::seg_count(N):0]   seg_carry
);
  import csla_pkg::*;

  localparam int NSEG = seg_count(N);

  logic [N:0] msk;
  logic [N:0] low_total;
  int         pos;

  always_comb begin
    msk       = '0;
    low_total = '0;
    pos       = 0;

    // R1
    sum_exact_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin}))
      else $error("sum mismatch");

    // R5
    if (a == '0 && b == '0) begin
      zero_operand_chk: assert (cout == 1'b0 && sum == {{(N-1){1'b0}}, cin})
        else $error("zero operands");
    end

    // R6
    if (a == ~b) begin
      complement_chk: assert ({cout, sum} == (cin ? {1'b1, {N{1'b0}}} : {1'b0, {N{1'b1}}}))
        else $error("complement operands");
    end

    // R3
    for (int g = 0; g <= NSEG; g++) begin
      pos       = (g == NSEG) ? N : seg_lo(N, g);
      msk       = ~({(N+1){1'b1}} << pos);
      low_total = ({1'b0, a} & msk) + ({1'b0, b} & msk) + {{N{1'b0}}, cin};
      seg_carry_chk: assert (seg_carry[g] == low_total[pos])
        else $error("segment carry %0d", g);
    end
  end
endmodule

bind csla_adder csla_adder_chk #(.N(N)) i_csla_adder_chk (
  .a         (a),
  .b         (b),
  .cin       (cin),
  .sum       (sum),
  .cout      (cout),
  .seg_carry (seg_carry)
);

// File: tb/test_csla_adder.sv
module test_csla_adder;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] va = '0;
  logic [63:0] vb = '0;
  logic        vc = 1'b0;

  logic [7:0]  s8;
  logic [15:0] s16;
  logic [31:0] s32;
  logic [63:0] s64;
  logic        c8, c16, c32, c64;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  csla_adder #(.N(16)) i_csla_adder (
    .a(va[15:0]), .b(vb[15:0]), .cin(vc), .sum(s16), .cout(c16));
  csla_adder #(.N(8)) i_csla_adder_w8 (
    .a(va[7:0]), .b(vb[7:0]), .cin(vc), .sum(s8), .cout(c8));
  csla_adder #(.N(32)) i_csla_adder_w32 (
    .a(va[31:0]), .b(vb[31:0]), .cin(vc), .sum(s32), .cout(c32));
  csla_adder #(.N(64)) i_csla_adder_w64 (
    .a(va), .b(vb), .cin(vc), .sum(s64), .cout(c64));

  function automatic logic [64:0] expect_w(int w);
    logic [63:0] m;
    logic [64:0] t;
    m = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    t = {1'b0, va & m} + {1'b0, vb & m} + {64'd0, vc};
    return t & {1'b0, m} | ({64'd0, t[w]} << w);
  endfunction

  function automatic logic [64:0] got_w(int w);
    case (w)
      8:       return {56'd0, c8, s8};
      16:      return {48'd0, c16, s16};
      32:      return {32'd0, c32, s32};
      default: return {c64, s64};
    endcase
  endfunction

  task automatic check(string req, int w, logic [64:0] got, logic [64:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s N=%0d a=%h b=%h cin=%0d got %h expected %h",
               req, w, va, vb, vc, got, exp);
    end
  endtask

  task automatic drive(logic [63:0] a, logic [63:0] b, logic c);
    va = a; vb = b; vc = c;
    #1;
  endtask

  task automatic check_all(string req);
    check(req, 8,  got_w(8),  expect_w(8));
    check(req, 16, got_w(16), expect_w(16));
    check(req, 32, got_w(32), expect_w(32));
    check(req, 64, got_w(64), expect_w(64));
  endtask

  // R5: zero operands, with and without carry-in
  task automatic t_zero_operands();
    drive('0, '0, 1'b0);
    check_all("R5 zero");
    drive('0, '0, 1'b1);
    check_all("R5 carry only");
    check("R5 carry only literal", 16, got_w(16), 65'd1);
  endtask

  // R1 R8: every 8-bit operand pair and carry
  task automatic t_exhaustive8();
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        for (int c = 0; c < 2; c++) begin
          drive(64'(i), 64'(j), c[0]);
          check("R1 R8 exhaustive", 8, got_w(8), expect_w(8));
        end
      end
    end
  endtask

  // R1 R8: random vectors at all widths
  task automatic t_random();
    for (int k = 0; k < 3000; k++) begin
      drive({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
      check_all("R1 R8 random");
    end
  endtask

  // R4: carry crosses every segment
  task automatic t_full_ripple();
    drive({64{1'b1}}, '0, 1'b1);
    check_all("R4 full ripple");
    check("R4 literal", 16, got_w(16), {48'd0, 1'b1, 16'h0000});
    drive({64{1'b1}}, {64{1'b1}}, 1'b1);
    check_all("R4 ones plus ones");
  endtask

  // R6: complementary operands
  task automatic t_complement();
    drive(64'hA5C3_0F96_1234_FEDC, ~64'hA5C3_0F96_1234_FEDC, 1'b0);
    check_all("R6 complement cin0");
    check("R6 literal cin0", 16, got_w(16), {48'd0, 1'b0, 16'hFFFF});
    drive(64'hA5C3_0F96_1234_FEDC, ~64'hA5C3_0F96_1234_FEDC, 1'b1);
    check_all("R6 complement cin1");
    check("R6 literal cin1", 16, got_w(16), {48'd0, 1'b1, 16'h0000});
  endtask

  // R2 R3: a carry landing on each bit position, so on every segment edge
  task automatic t_boundaries();
    for (int p = 1; p < 64; p++) begin
      drive((64'd1 << p) - 64'd1, 64'd1, 1'b0);
      check_all("R3 carry into bit");
      drive((64'd1 << p) - 64'd1, 64'd0, 1'b1);
      check_all("R3 cin into bit");
    end
    // R2: 16-bit segment edges at bits 2, 4, 7, 11
    drive(64'h0000_0000_0000_007F, 64'd1, 1'b0);
    check("R2 edge 7", 16, got_w(16), 65'h0080);
    drive(64'h0000_0000_0000_07FF, 64'd0, 1'b1);
    check("R2 edge 11", 16, got_w(16), 65'h0800);
    drive(64'h0000_0000_0000_000F, 64'd1, 1'b0);
    check("R2 edge 4 at N=8", 8, got_w(8), 65'h010);
  endtask

  // R7: propagate-only segments wrap to zero under an incoming carry
  task automatic t_wrap();
    drive(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1);
    check_all("R7 wrap all segments");
    drive(64'h0000_0000_0000_07FF, 64'h0000_0000_0000_F800, 1'b1);
    check("R7 top segment wrap", 16, got_w(16), {48'd0, 1'b1, 16'h0000});
    drive(64'h0000_0000_0000_0078, 64'h0000_0000_0000_0007, 1'b1);
    check("R7 mid segment wrap", 16, got_w(16), 65'h0080);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_zero_operands();
    t_full_ripple();
    t_complement();
    t_boundaries();
    t_wrap();
    t_exhaustive8();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog run did not complete got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule